// File: doc/BRIEF.md
# System Control Port with Fast A20 Gate and Reset Trigger

This block is a one-byte control register that a host reaches through a simple byte-wide I/O bus at a single fixed port address. Each write to that address replaces the whole stored byte, and each read returns the byte unchanged. Two bits of the byte have side effects. Bit 1 drives the fast address-line-20 gate level. Bit 0 requests a CPU reset, and only a rising edge of bit 0 caused by a write does so.

The reset request is a single-clock pulse. It is registered, so it appears in the cycle after the write strobe. A device (soft) reset clears only bit 0 and keeps the other seven bits, so the A20 gate keeps its level through it. A power-on reset clears the whole byte. Accesses to any other address have no effect, and a read at another address returns all ones. The bus port and the outputs are plain control pins, with no stream interface and no back-pressure.

Top module: `sys_ctl_port`

## Requirements
- R1: After power-on reset the stored byte is 0x00, `a20_gate` is low and `cpu_rst_req` is low.
- R2: A write strobe with `bus_addr` equal to 0x0092 stores all 8 bits of `bus_wdata`. A read at 0x0092 returns the stored byte on `bus_rdata`, combinationally, while `bus_rd` is held.
- R3: `a20_gate` equals bit 1 of the stored byte. It updates in the cycle after every write to 0x0092.
- R4: A write to 0x0092 with data bit 0 = 1, while stored bit 0 is 0, raises `cpu_rst_req` for exactly one clock cycle, starting the cycle after the write strobe.
- R5: A write to 0x0092 that leaves bit 0 at 1 (1 over 1), or that writes bit 0 = 0, produces no pulse.
- R6: A `soft_rst` cycle without a write clears only stored bit 0. Bits 7..1 and `a20_gate` keep their values.
- R7: A write to any address other than 0x0092 changes nothing and gives no pulse. A read at any other address returns 0xFF.
- R8: When a write to 0x0092 and `soft_rst` fall in the same cycle, bits 7..1 take the written data, bit 0 becomes 0, and no pulse is produced.
- R9: After a soft reset has cleared bit 0, a write of bit 0 = 1 produces a new pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, clears the whole byte |
| soft_rst | input | 1 | Device reset, clears bit 0 only |
| bus_addr | input | 16 | I/O address of the access |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data: the stored byte on a hit, 0xFF on a miss |
| a20_gate | output | 1 | A20 gate level, stored bit 1 |
| cpu_rst_req | output | 1 | One-cycle CPU reset request |

## Verification
The stored byte, `a20_gate` and `cpu_rst_req` all change on the clock edge that samples the write strobe. They are therefore due one cycle after the stimulus. Read data is due in the same cycle as the read strobe. The driver sets the inputs just after a falling edge and holds them until the next falling edge. When the rising edge has taken the inputs, it queues the expected values. The monitor compares them at the following falling edge, while the inputs are still held. The expected pulse is queued for exactly one step, and the next step expects the pulse to be low again.

// File: rtl/syscp_pkg.sv
package syscp_pkg;
  localparam int unsigned BYTE_W = 8;
  typedef logic [BYTE_W-1:0] ctl_byte_t;
endpackage

// File: rtl/syscp_decode.sv
module syscp_decode #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 'h92
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  output logic              wr_hit,
  output logic              rd_hit
);
  logic match;
  always_comb begin
    match  = (addr == PORT_ADDR);
    wr_hit = wr && match;
    rd_hit = rd && match;
  end
endmodule

// File: rtl/syscp_store.sv
module syscp_store
  import syscp_pkg::*;
#(
  parameter int unsigned RST_BIT = 0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      soft_clr,
  input  logic      wr_en,
  input  ctl_byte_t wdata,
  output ctl_byte_t ctl_q
);
  ctl_byte_t ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en) ctl_d = wdata;
    // soft reset wins over a simultaneous write, for the reset bit only
    if (soft_clr) ctl_d[RST_BIT] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end
endmodule

// File: rtl/syscp_pulse.sv
module syscp_pulse
  import syscp_pkg::*;
#(
  parameter int unsigned RST_BIT = 0
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      soft_clr,
  input  logic      wr_en,
  input  ctl_byte_t wdata,
  input  ctl_byte_t ctl_q,
  output logic      req_q
);
  logic rise;
  always_comb rise = wr_en && wdata[RST_BIT] && !ctl_q[RST_BIT] && !soft_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= 1'b0;
    else        req_q <= rise;
  end
endmodule

// File: rtl/sys_ctl_port.sv
module sys_ctl_port
  import syscp_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 'h92,
  parameter int unsigned RST_BIT   = 0,
  parameter int unsigned GATE_BIT  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_rd,
  output logic [7:0]        bus_rdata,
  output logic              a20_gate,
  output logic              cpu_rst_req
);
  localparam ctl_byte_t MISS_VAL = '1;

  logic      wr_hit, rd_hit;
  ctl_byte_t ctl_q;

  syscp_decode #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_dec (
    .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wr_hit(wr_hit), .rd_hit(rd_hit)
  );

  syscp_store #(.RST_BIT(RST_BIT)) u_store (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_rst),
    .wr_en(wr_hit), .wdata(bus_wdata), .ctl_q(ctl_q)
  );

  syscp_pulse #(.RST_BIT(RST_BIT)) u_pulse (
    .clk(clk), .rst_n(rst_n), .soft_clr(soft_rst),
    .wr_en(wr_hit), .wdata(bus_wdata), .ctl_q(ctl_q),
    .req_q(cpu_rst_req)
  );

  always_comb begin
    bus_rdata = rd_hit ? ctl_q : MISS_VAL;
    a20_gate  = ctl_q[GATE_BIT];
  end
endmodule

// File: rtl/syscp_checker.sv
module syscp_checker #(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 'h92
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [7:0]        bus_wdata,
  input logic              bus_rd,
  input logic [7:0]        bus_rdata,
  input logic              a20_gate,
  input logic              cpu_rst_req,
  input logic [7:0]        ctl_q
);
  logic wr_at;
  always_comb wr_at = bus_wr && (bus_addr == PORT_ADDR);

  p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rst_req |=> !cpu_rst_req);

  p_pulse_on_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_at && bus_wdata[0] && !ctl_q[0] && !soft_rst) |=> cpu_rst_req);

  p_no_pulse_held_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_at && ctl_q[0]) |=> !cpu_rst_req);

  p_gate_follows_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_at |=> (a20_gate == $past(bus_wdata[1])));

  p_soft_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && !bus_wr) |=> (!ctl_q[0] && ctl_q[7:1] == $past(ctl_q[7:1])));

  p_both_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && wr_at) |=> (!cpu_rst_req && ctl_q == {$past(bus_wdata[7:1]), 1'b0}));

  p_miss_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_at && !soft_rst) |=> $stable(ctl_q));

  always_comb begin
    if (rst_n && bus_rd && bus_addr != PORT_ADDR)
      p_miss_read_r7: assert (bus_rdata == 8'hFF);
  end
endmodule

bind sys_ctl_port syscp_checker #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .bus_addr(bus_addr),
  .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .a20_gate(a20_gate), .cpu_rst_req(cpu_rst_req),
  .ctl_q(ctl_q)
);

// File: tb/sim_sys_ctl_port.sv
`timescale 1ns/1ps
module sim_sys_ctl_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        soft_rst = 1'b0;
  logic [15:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic        a20_gate;
  logic        cpu_rst_req;

  always #2 clk = ~clk;

  sys_ctl_port u0 (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .a20_gate(a20_gate), .cpu_rst_req(cpu_rst_req)
  );

  typedef struct {
    logic       req;
    logic       a20;
    logic       chk_rd;
    logic [7:0] rd;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   total = 0;
  int   bad = 0;
  bit   done = 1'b0;
  logic [7:0] model = 8'h00;

  // monitor: compares at the falling edge, inputs still held
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if (cpu_rst_req !== e.req) begin
        bad++;
        $display("FAIL %s cpu_rst_req got=%b exp=%b", e.tag, cpu_rst_req, e.req);
      end
      total++;
      if (a20_gate !== e.a20) begin
        bad++;
        $display("FAIL %s a20_gate got=%b exp=%b", e.tag, a20_gate, e.a20);
      end
      if (e.chk_rd) begin
        total++;
        if (bus_rdata !== e.rd) begin
          bad++;
          $display("FAIL %s bus_rdata got=%02h exp=%02h", e.tag, bus_rdata, e.rd);
        end
      end
    end
  end

  // one bus step: optional write, optional read, optional soft reset
  task automatic step(input logic [15:0] a, input logic w, input logic [7:0] d,
                      input logic r, input logic sr, input string tag);
    exp_t e;
    logic hit;
    logic fire;
    @(negedge clk); #1;
    bus_addr = a; bus_wr = w; bus_wdata = d; bus_rd = r; soft_rst = sr;
    hit  = (a == 16'h0092);
    fire = w && hit && d[0] && !model[0] && !sr;
    if (w && hit) model = d;
    if (sr) model[0] = 1'b0;
    @(posedge clk);
    e.req = fire; e.a20 = model[1]; e.chk_rd = r;
    e.rd = hit ? model : 8'hFF; e.tag = tag;
    q.push_back(e);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    step(16'h0092, 0, 8'h00, 1, 0, "R1 reset state");
    step(16'h0092, 1, 8'h02, 0, 0, "R3 gate set");
    step(16'h0092, 0, 8'h00, 1, 0, "R2 readback 02");
    step(16'h0092, 1, 8'hA5, 0, 0, "R4 rising bit0 pulse");
    step(16'h0092, 0, 8'h00, 1, 0, "R4 pulse single cycle, R2 readback A5");
    step(16'h0092, 1, 8'hFF, 0, 0, "R5 one over one");
    step(16'h0092, 1, 8'h03, 1, 0, "R5 one over one again");
    step(16'h0092, 0, 8'h00, 0, 1, "R6 soft reset keeps upper bits");
    step(16'h0092, 0, 8'h00, 1, 0, "R6 readback after soft reset");
    step(16'h0093, 1, 8'h01, 0, 0, "R7 write elsewhere ignored");
    step(16'h0093, 0, 8'h00, 1, 0, "R7 read elsewhere is FF");
    step(16'h0092, 0, 8'h00, 1, 0, "R7 stored byte untouched");
    step(16'h0092, 1, 8'h01, 0, 0, "R9 pulse after soft reset");
    step(16'h0092, 1, 8'h00, 1, 0, "R5 writing zero gives no pulse");
    step(16'h0092, 1, 8'h47, 0, 1, "R8 write with soft reset");
    step(16'h0092, 0, 8'h00, 1, 0, "R8 readback 46");
    step(16'h0092, 1, 8'h0B, 0, 1, "R8 rising bit0 suppressed");
    step(16'h0092, 1, 8'h0B, 0, 0, "R9 rising bit0 fires after");
    step(16'h0092, 0, 8'h00, 1, 0, "R2 readback 0B");
    step(16'h0092, 1, 8'h5C, 0, 0, "R3 gate clear");
    step(16'h0092, 0, 8'h00, 1, 0, "R2 readback 5C");
    @(negedge clk); #1;
    bus_wr = 1'b0; bus_rd = 1'b0; soft_rst = 1'b0;
    while (q.size() > 0) @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule